// File: doc/BRIEF.md
# Transposed Band-Pass FIR for 3-Bit Samples

This block band-limits one channel of coarsely quantized receiver data. Each clock it can accept one 3-bit sample, marked by a valid strobe, and it returns one signed filtered value at a parameter width. The filter has 31 taps in transposed form. Every accepted sample goes to all taps in the same cycle. Each tap adds its own product to the partial sum arriving from its neighbour and registers the result, so no adder in the chain has more than two inputs.

Because a sample can take only eight values, every tap product is read from an eight-entry table that is computed from the tap's coefficient at elaboration. No multiplier is built. Taps whose coefficient is zero keep only a delay register. The coefficient set is a parameter array. The default is a symmetric, linear-phase band-pass response on a ×1024 integer scale, in which every tap with an even index is zero. A rounding stage reduces the full-precision sum to the output width.

Top module: `bpf_transposed_fir`

## Requirements
- R1: The 3-bit code c is read as a two's-complement integer s in the range -4..3, and it stands for the odd level 2s+1. So 000 is +1, 011 is +7, 100 is -7 and 111 is -1.
- R2: For the n-th accepted sample, the full-precision result is y = sum over k of h[k]·level(x[n-k]), where h is the coefficient array. Samples from before the last reset count as zero. The output is floor((y + 2^(SH-1)) / 2^SH), with SH = accumulator width minus OUT_W, which rounds halves toward plus infinity.
- R3: The accumulator is 4 + COEF_W + clog2(NTAPS) bits wide and never overflows. With the default coefficients, the worst-case sign-aligned input gives y = 10794, which becomes output 1349, and the mirrored input gives output -1349.
- R4: out_valid is high exactly on the second rising edge after the edge that captured a sample with in_valid high, and out_data carries that sample's result.
- R5: In a cycle with in_valid low the filter state does not advance, so idle gaps change neither later results nor their order. Two edges after an idle cycle, out_valid is low.
- R6: With the default coefficients (DC sum -10), a long run of code 011 settles to output -9 and a long run of code 100 settles to output +9.
- R7: A synchronous reset clears every partial sum, out_valid and out_data. Results after reset depend only on samples accepted after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies in_code in this cycle |
| in_code | input | 3 | Sample code (two's complement, odd-level mapping) |
| out_valid | output | 1 | out_data holds a new result |
| out_data | output | OUT_W | Rounded signed filter output |

## Verification
The bench targets four kinds of error.

- **Sample mapping and chain ordering.** An impulse-like input and a long random stream are checked against a direct-form model. A wrong code-to-level mapping or a tap wired into the wrong place in the chain would show up as wrong values.
- **Idle gaps.** Idle cycles are scattered through the stream. A chain that advanced without a valid sample would shift every later result, and an off-by-one valid pipeline would put out_valid in the wrong cycle.
- **Overflow and rounding.** A sign-aligned worst-case sequence would wrap a narrow accumulator. The constant-input runs land on a fractional sum of -8.75, so the wrong rounding direction would show up there.
- **Reset.** A reset in the middle of the stream must discard the samples still in the chain.

// File: rtl/bpf_pkg.sv
package bpf_pkg;

   // Width of one sample code and of its signed odd level.
   localparam int CODE_W  = 3;
   localparam int LVL_W   = CODE_W + 1;
   localparam int LVL_MAX = (2 ** CODE_W) - 1;

   // Odd level for a code given as an integer 0..2^CODE_W-1.
   function automatic int level_of_int(input int c);
      int s;
      s = (c >= (2 ** (CODE_W - 1))) ? c - (2 ** CODE_W) : c;
      return 2 * s + 1;
   endfunction

   // Accumulator width that cannot overflow for any input pattern.
   function automatic int acc_width(input int coef_w, input int ntaps);
      return LVL_W + coef_w + $clog2(ntaps);
   endfunction

endpackage

// File: rtl/bpf_tap_lut.sv
module bpf_tap_lut #(
   parameter int                         COEF_W = 10,
   parameter int                         ACC_W  = 19,
   parameter logic signed [COEF_W-1:0]   COEF   = '0
) (
   input  logic [bpf_pkg::CODE_W-1:0]    code,
   output logic signed [ACC_W-1:0]       prod
);

   localparam int N_ENT = 2 ** bpf_pkg::CODE_W;

   logic signed [ACC_W-1:0] rom [N_ENT];

   // One entry per code: coefficient times the code's odd level.
   for (genvar i = 0; i < N_ENT; i++) begin : g_ent
      localparam int LV = bpf_pkg::level_of_int(i);
      localparam int PV = int'(COEF) * LV;
      assign rom[i] = ACC_W'(PV);
   end

   assign prod = rom[code];

endmodule

// File: rtl/bpf_tap_stage.sv
module bpf_tap_stage #(
   parameter int                         COEF_W = 10,
   parameter int                         ACC_W  = 19,
   parameter logic signed [COEF_W-1:0]   COEF   = '0
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          en,
   input  logic [bpf_pkg::CODE_W-1:0]    code,
   input  logic signed [ACC_W-1:0]       sum_in,
   output logic signed [ACC_W-1:0]       sum_q
);

   if (COEF == '0) begin : g_delay
      // Zero coefficient: the tap is pruned to a plain delay register.
      logic unused_code;
      assign unused_code = ^code;

      always_ff @(posedge clk) begin
         if (rst)     sum_q <= '0;
         else if (en) sum_q <= sum_in;
      end
   end else begin : g_mac
      logic signed [ACC_W-1:0] prod;

      bpf_tap_lut #(
         .COEF_W (COEF_W),
         .ACC_W  (ACC_W),
         .COEF   (COEF)
      ) u_lut (
         .code (code),
         .prod (prod)
      );

      // Two-input adder feeding the register of this tap.
      always_ff @(posedge clk) begin
         if (rst)     sum_q <= '0;
         else if (en) sum_q <= sum_in + prod;
      end
   end

endmodule

// File: rtl/bpf_round.sv
module bpf_round #(
   parameter int ACC_W = 19,
   parameter int OUT_W = 16
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    en,
   input  logic signed [ACC_W-1:0] acc,
   output logic signed [OUT_W-1:0] out_q
);

   localparam int SH = ACC_W - OUT_W;

   if (SH == 0) begin : g_pass
      always_ff @(posedge clk) begin
         if (rst)     out_q <= '0;
         else if (en) out_q <= acc;
      end
   end else begin : g_rnd
      localparam logic signed [ACC_W:0] HALF = (ACC_W + 1)'(2 ** (SH - 1));
      localparam logic signed [ACC_W:0] MAXV = (ACC_W + 1)'((2 ** (OUT_W - 1)) - 1);
      localparam logic signed [ACC_W:0] MINV = -MAXV - (ACC_W + 1)'(1);

      logic signed [ACC_W:0]   biased;
      logic signed [ACC_W:0]   scaled;
      logic signed [OUT_W-1:0] sat;

      // Add half an LSB of the output, then shift arithmetically.
      always_comb begin
         biased = $signed({acc[ACC_W-1], acc}) + HALF;
         scaled = biased >>> SH;
         if (scaled > MAXV)      sat = MAXV[OUT_W-1:0];
         else if (scaled < MINV) sat = MINV[OUT_W-1:0];
         else                    sat = scaled[OUT_W-1:0];
      end

      always_ff @(posedge clk) begin
         if (rst)     out_q <= '0;
         else if (en) out_q <= sat;
      end

      // R2: a registered result lies within half an output step of the sum.
      p_round_err_r2: assert property (@(posedge clk) disable iff (rst)
         en |=> (((int'(out_q) * (2 ** SH)) - int'($past(acc))) <= (2 ** (SH - 1)))
             && (((int'(out_q) * (2 ** SH)) - int'($past(acc))) >  -(2 ** (SH - 1))));
   end

endmodule

// File: rtl/bpf_transposed_fir.sv
module bpf_transposed_fir #(
   parameter int                       NTAPS  = 31,
   parameter int                       COEF_W = 10,
   parameter int                       OUT_W  = 16,
   parameter logic signed [COEF_W-1:0] COEF [NTAPS] = '{
      10'sd0, -10'sd12, 10'sd0,   10'sd4,   10'sd0,  10'sd36,  10'sd0,  -10'sd76,
      10'sd0, 10'sd36,  10'sd0,   10'sd114, 10'sd0,  -10'sd300, 10'sd0, 10'sd386,
      10'sd0, -10'sd300, 10'sd0,  10'sd114, 10'sd0,  10'sd36,  10'sd0,  -10'sd76,
      10'sd0, 10'sd36,  10'sd0,   10'sd4,   10'sd0,  -10'sd12, 10'sd0}
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         in_valid,
   input  logic [bpf_pkg::CODE_W-1:0]   in_code,
   output logic                         out_valid,
   output logic [OUT_W-1:0]             out_data
);

   localparam int ACC_W = bpf_pkg::acc_width(COEF_W, NTAPS);

   function automatic int coef_abs_sum();
      int s;
      s = 0;
      for (int k = 0; k < NTAPS; k++)
         s += (COEF[k] < 0) ? -int'(COEF[k]) : int'(COEF[k]);
      return s;
   endfunction

   localparam int PEAK = bpf_pkg::LVL_MAX * coef_abs_sum();

   // Elaboration-time parameter checks.
   if (NTAPS < 2)        begin : g_bad_taps  $error("NTAPS must be at least 2");      end
   if (COEF_W < 2)       begin : g_bad_coef  $error("COEF_W must be at least 2");     end
   if (ACC_W > 31)       begin : g_bad_acc   $error("accumulator wider than 31 bits"); end
   if (OUT_W > ACC_W)    begin : g_bad_out   $error("OUT_W exceeds accumulator width"); end
   if (OUT_W < 2)        begin : g_bad_out2  $error("OUT_W must be at least 2");      end

   // chain[NTAPS] seeds the far end of the adder chain with zero.
   logic [NTAPS:0][ACC_W-1:0] chain;
   logic signed [ACC_W-1:0]   head;
   logic                      v_d1;
   logic signed [OUT_W-1:0]   rnd_q;

   assign chain[NTAPS] = '0;

   for (genvar k = 0; k < NTAPS; k++) begin : g_tap
      bpf_tap_stage #(
         .COEF_W (COEF_W),
         .ACC_W  (ACC_W),
         .COEF   (COEF[k])
      ) u_stage (
         .clk    (clk),
         .rst    (rst),
         .en     (in_valid),
         .code   (in_code),
         .sum_in (chain[k+1]),
         .sum_q  (chain[k])
      );
   end

   assign head = chain[0];

   always_ff @(posedge clk) begin
      if (rst) begin
         v_d1      <= 1'b0;
         out_valid <= 1'b0;
      end else begin
         v_d1      <= in_valid;
         out_valid <= v_d1;
      end
   end

   bpf_round #(
      .ACC_W (ACC_W),
      .OUT_W (OUT_W)
   ) u_round (
      .clk   (clk),
      .rst   (rst),
      .en    (v_d1),
      .acc   (head),
      .out_q (rnd_q)
   );

   assign out_data = rnd_q;

   // R3: the full-precision sum stays within the bound of the coefficient set.
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
      (int'(head) <= PEAK) && (int'(head) >= -PEAK));

   // R4: an accepted sample yields a result two edges later.
   p_valid_latency_r4: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> ##1 out_valid);

   // R5: an idle cycle neither moves the chain nor produces a result.
   p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(head) ##1 !out_valid);

   // R7: reset empties the chain and the output strobe.
   p_reset_clear_r7: assert property (@(posedge clk)
      rst |=> (head == '0) && !out_valid && (out_data == '0));

endmodule

// File: tb/bpf_transposed_fir_bench.sv
module bpf_transposed_fir_bench;

   localparam int NT = 31;
   localparam int SH = 3;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [2:0]  in_code = 3'd0;
   logic        out_valid;
   logic [15:0] out_data;

   always #2 clk = ~clk;

   bpf_transposed_fir u_bpf_transposed_fir (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_code   (in_code),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   // Coefficients as stated in the requirements, written independently here.
   int h [NT] = '{0, -12, 0, 4, 0, 36, 0, -76, 0, 36, 0, 114, 0, -300, 0, 386,
                  0, -300, 0, 114, 0, 36, 0, -76, 0, 36, 0, 4, 0, -12, 0};

   typedef struct {
      int    exp;
      string tag;
   } item_t;

   item_t  sb [$];
   int     hist [NT];
   int     n_cmp = 0;
   int     n_bad = 0;
   logic [1:0] vpipe = 2'b00;
   bit     done = 1'b0;

   function automatic int lvl(input int c);
      return ((c >= 4) ? c - 8 : c) * 2 + 1;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Driver: present one sample and push its reference result.
   task automatic send(input int c, input string tag);
      int y;
      @(negedge clk);
      in_valid = 1'b1;
      in_code  = c[2:0];
      for (int i = NT - 1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = lvl(c);
      y = 0;
      for (int i = 0; i < NT; i++) y += h[i] * hist[i];
      sb.push_back('{(y + 4) >>> SH, tag});
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst      = 1'b1;
      in_valid = 1'b0;
      sb.delete();
      for (int i = 0; i < NT; i++) hist[i] = 0;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R7 out_valid in reset", int'(out_valid), 0);
      check(out_data == 16'd0, "R7 out_data in reset", int'($signed(out_data)), 0);
      rst = 1'b0;
   endtask

   // Independent model of the valid pipeline.
   always @(posedge clk) begin
      if (rst) vpipe <= 2'b00;
      else     vpipe <= {vpipe[0], in_valid};
   end

   // Monitor: sample just after each rising edge.
   always @(posedge clk) begin
      item_t it;
      #1;
      if (!rst) begin
         check(out_valid == vpipe[1], "R4/R5 out_valid timing",
               int'(out_valid), int'(vpipe[1]));
         if (out_valid) begin
            if (sb.size() == 0) begin
               check(1'b0, "R4 unexpected result", int'($signed(out_data)), 0);
            end else begin
               it = sb.pop_front();
               check(int'($signed(out_data)) == it.exp, it.tag,
                     int'($signed(out_data)), it.exp);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NT; i++) hist[i] = 0;
      apply_reset();

      // R1: impulse-like pattern, one +7 among alternating +1 / -1.
      send(3, "R1 impulse");
      for (int j = 0; j < 34; j++) send((j % 2) ? 0 : 7, "R1/R2 impulse tail");

      // R6: DC response for both extreme levels.
      for (int j = 0; j < 40; j++) send(3, "R6 dc plus7");
      for (int j = 0; j < 40; j++) send(4, "R6 dc minus7");

      // R3: sign-aligned worst case in both polarities.
      for (int j = 0; j < NT; j++) send((h[NT-1-j] >= 0) ? 3 : 4, "R3 peak positive");
      for (int j = 0; j < NT; j++) send((h[NT-1-j] >= 0) ? 4 : 3, "R3 peak negative");
      idle(4);

      // R2 and R5: random samples with scattered idle gaps.
      for (int j = 0; j < 1500; j++) begin
         if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
         send(int'($urandom % 8), "R2/R5 random");
      end

      // R7: reset while samples are still in flight, then restart.
      for (int j = 0; j < 10; j++) send(int'($urandom % 8), "R7 before reset");
      apply_reset();
      for (int j = 0; j < 40; j++) send(int'($urandom % 8), "R7 after reset");

      idle(6);
      check(sb.size() == 0, "R4 all results delivered", sb.size(), 0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule